// File: doc/BRIEF.md
# TLB Address-Array Write Engine

This block owns the address side of two translation buffers: a 64-entry unified TLB and a 4-entry instruction TLB. Each entry holds a virtual page number, an address-space identifier, a shared flag, a valid bit and a dirty bit. A single write strobe carrying a 32-bit address and 32-bit data acts in one of two ways. In the first way it stores straight into one unified entry picked by the address. In the second it starts a search over both buffers that updates valid and dirty state wherever the page and identifier match.

The search walks the unified buffer one entry per clock with `busy_o` high. Every examined entry produces one strobe for the replacement counter. A second hit stops the walk and raises a multiple-hit exception that reports the write address. A final cycle then updates the first matching instruction entry. Whenever a mapping loses validity, or a valid unified entry is overwritten directly, an invalidate pulse gives the page address so that cached translations can be dropped. A side port loads whole entries from the refill path, and a combinational read port exposes any entry.

Top module: `tlb_addr_wr`

## Requirements
- R1: After reset every entry of both buffers reads all-zero (invalid), and `busy_o`, `urc_inc_o`, `exc_o` and `inval_o` are low.
- R2: A write with address bit 7 = 0 stores into unified entry address[13:8]. It sets page = data[31:10], dirty = data[9], valid = data[8] and identifier = data[7:0], and keeps the shared flag. `urc_inc_o` pulses once, in the cycle after the write, and `busy_o` stays low.
- R3: If a direct write replaces an entry that was valid, `inval_o` pulses in the cycle after the write with `inval_addr_o` = {old page, 10'b0}.
- R4: A write with address bit 7 = 1 starts a search. `busy_o` is high for 65 cycles, starting in the cycle after the write. Every valid unified entry that matches takes the new valid and dirty bits and keeps its page and identifier.
- R5: An entry matches when its page equals data[31:10] and one of three conditions holds: its identifier equals data[7:0], its shared flag is set, or `use_asid_i` was low at the write.
- R6: On a second unified match, `exc_o` pulses for one cycle with `exc_code_o` = 0x140 and `tea_o` = the write address. That entry is left unchanged, the walk stops, and `busy_o` falls in the cycle after the pulse.
- R7: In the last search cycle, the lowest-index instruction entry that matches is updated. Its valid bit is not part of the match. If a unified entry matched, the instruction entry becomes a copy of it. Otherwise only its valid bit is set to data[8].
- R8: During a search, `urc_inc_o` pulses once for each unified entry examined. That is 64 pulses with no duplicate, or k pulses when the second hit is at index k.
- R9: If a search turns any valid entry invalid in either buffer, `inval_o` pulses once, in the first cycle with `busy_o` low, with `inval_addr_o` = {data[31:10], 10'b0}.
- R10: Writes and refill loads presented while `busy_o` is high are ignored.
- R11: A refill load (`fill_i`, with `fill_itlb_i` picking the buffer) writes a whole entry with no `urc_inc_o` pulse. The read port returns any entry combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Address-array write strobe |
| waddr_i | input | 32 | Write address: bit 7 mode, bits 13:8 index |
| wdata_i | input | 32 | Write data: page, dirty, valid, identifier |
| use_asid_i | input | 1 | Identifier comparison enabled |
| fill_i | input | 1 | Refill load strobe |
| fill_itlb_i | input | 1 | Refill target: 1 instruction, 0 unified |
| fill_idx_i | input | 6 | Refill entry index |
| fill_vpn_i | input | 22 | Refill page number |
| fill_asid_i | input | 8 | Refill identifier |
| fill_sh_i | input | 1 | Refill shared flag |
| fill_v_i | input | 1 | Refill valid bit |
| fill_d_i | input | 1 | Refill dirty bit |
| rd_itlb_i | input | 1 | Read target: 1 instruction, 0 unified |
| rd_idx_i | input | 6 | Read entry index |
| rd_vpn_o | output | 22 | Read page number |
| rd_asid_o | output | 8 | Read identifier |
| rd_sh_o | output | 1 | Read shared flag |
| rd_v_o | output | 1 | Read valid bit |
| rd_d_o | output | 1 | Read dirty bit |
| busy_o | output | 1 | Search in progress |
| urc_inc_o | output | 1 | Replacement-counter advance strobe |
| exc_o | output | 1 | Multiple-hit exception pulse |
| exc_code_o | output | 12 | Exception code, 0x140 while `exc_o` is high |
| tea_o | output | 32 | Faulting write address |
| inval_o | output | 1 | Page invalidate pulse |
| inval_addr_o | output | 32 | Page address to invalidate |

## Verification
A direct write that overwrites a valid entry raises the counter strobe and the invalidate pulse in the same cycle. A search that clears a valid entry sends its last counter strobe just one cycle before the invalidate pulse. Both cases are set up by preloading entries through the refill port. A scoreboard queue holds events in a fixed order within each cycle (exception, invalidate, counter), so an event that goes missing, arrives extra, or arrives one cycle early shows up as a mismatch. The duplicate-hit case checks that the exception comes in place of a counter strobe and never alongside one. Writes and loads driven during a busy window are judged by reading the targeted entries back afterwards.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  localparam int VPN_W  = 22;
  localparam int ASID_W = 8;
  localparam logic [11:0] MHIT_CODE = 12'h140;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              sh;
    logic              v;
    logic              d;
  } tlb_ent_t;
endpackage

// File: rtl/tlbw_store.sv
module tlbw_store
  import tlbw_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  tlb_ent_t      wdata_i,
  output tlb_ent_t      ent_o [DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    tlb_ent_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= '0;
      else if (we_i && widx_i == IW'(g)) ent_q <= wdata_i;
    end
    assign ent_o[g] = ent_q;
  end
endmodule

// File: rtl/tlbw_ctrl.sv
module tlbw_ctrl
  import tlbw_pkg::*;
#(
  parameter int UTLB_N   = 64,
  parameter int ITLB_N   = 4,
  parameter int MODE_BIT = 7,
  parameter int IDX_LSB  = 8,
  localparam int UIW   = $clog2(UTLB_N),
  localparam int IIW   = (ITLB_N > 1) ? $clog2(ITLB_N) : 1,
  localparam int PG_SH = 32 - VPN_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [31:0]    waddr_i,
  input  logic [31:0]    wdata_i,
  input  logic           use_asid_i,
  input  logic           fill_i,
  input  logic           fill_itlb_i,
  input  logic [UIW-1:0] fill_idx_i,
  input  tlb_ent_t       fill_ent_i,
  input  tlb_ent_t       uent_i [UTLB_N],
  input  tlb_ent_t       ient_i [ITLB_N],
  output logic           u_we_o,
  output logic [UIW-1:0] u_widx_o,
  output tlb_ent_t       u_wdata_o,
  output logic           i_we_o,
  output logic [IIW-1:0] i_widx_o,
  output tlb_ent_t       i_wdata_o,
  output logic           busy_o,
  output logic           urc_inc_o,
  output logic           exc_o,
  output logic [31:0]    tea_o,
  output logic           inval_o,
  output logic [31:0]    inval_addr_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_ITLB} st_e;
  st_e state_q;

  logic [UIW-1:0]    idx_q, midx_q;
  logic [VPN_W-1:0]  s_vpn_q;
  logic [ASID_W-1:0] s_asid_q;
  logic              s_v_q, s_d_q, s_use_q, found_q, flush_q;
  logic [31:0]       s_addr_q;

  // write-data fields
  logic [VPN_W-1:0]  w_vpn;
  logic [ASID_W-1:0] w_asid;
  logic              w_v, w_d, start, assoc;
  logic [UIW-1:0]    d_idx;
  assign w_vpn  = wdata_i[31:PG_SH];
  assign w_d    = wdata_i[PG_SH-1];
  assign w_v    = wdata_i[PG_SH-2];
  assign w_asid = wdata_i[ASID_W-1:0];
  assign d_idx  = waddr_i[IDX_LSB +: UIW];
  assign start  = wr_i && (state_q == ST_IDLE);
  assign assoc  = waddr_i[MODE_BIT];
  assign busy_o = (state_q != ST_IDLE);

  tlb_ent_t cur;
  logic     u_hit;
  assign cur   = uent_i[idx_q];
  assign u_hit = cur.v && cur.vpn == s_vpn_q &&
                 (!s_use_q || cur.asid == s_asid_q || cur.sh);

  // lowest-index instruction entry wins; valid bit not part of match
  logic           i_hit;
  logic [IIW-1:0] i_hidx;
  always_comb begin
    i_hit  = 1'b0;
    i_hidx = '0;
    for (int j = ITLB_N - 1; j >= 0; j--) begin
      if (ient_i[j].vpn == s_vpn_q &&
          (!s_use_q || ient_i[j].asid == s_asid_q || ient_i[j].sh)) begin
        i_hit  = 1'b1;
        i_hidx = IIW'(j);
      end
    end
  end

  always_comb begin
    u_we_o    = 1'b0;
    u_widx_o  = d_idx;
    u_wdata_o = uent_i[d_idx];
    i_we_o    = 1'b0;
    i_widx_o  = i_hidx;
    i_wdata_o = ient_i[i_hidx];
    unique case (state_q)
      ST_IDLE: begin
        if (start && !assoc) begin
          u_we_o         = 1'b1;
          u_wdata_o.vpn  = w_vpn;
          u_wdata_o.asid = w_asid;
          u_wdata_o.v    = w_v;
          u_wdata_o.d    = w_d;
        end else if (!wr_i && fill_i) begin
          if (fill_itlb_i) begin
            i_we_o    = 1'b1;
            i_widx_o  = fill_idx_i[IIW-1:0];
            i_wdata_o = fill_ent_i;
          end else begin
            u_we_o    = 1'b1;
            u_widx_o  = fill_idx_i;
            u_wdata_o = fill_ent_i;
          end
        end
      end
      ST_SCAN: begin
        if (u_hit && !found_q) begin
          u_we_o      = 1'b1;
          u_widx_o    = idx_q;
          u_wdata_o   = cur;
          u_wdata_o.v = s_v_q;
          u_wdata_o.d = s_d_q;
        end
      end
      ST_ITLB: begin
        if (i_hit) begin
          i_we_o = 1'b1;
          if (found_q) i_wdata_o = uent_i[midx_q];
          else         i_wdata_o.v = s_v_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      midx_q       <= '0;
      s_vpn_q      <= '0;
      s_asid_q     <= '0;
      s_v_q        <= 1'b0;
      s_d_q        <= 1'b0;
      s_use_q      <= 1'b0;
      s_addr_q     <= '0;
      found_q      <= 1'b0;
      flush_q      <= 1'b0;
      urc_inc_o    <= 1'b0;
      exc_o        <= 1'b0;
      tea_o        <= '0;
      inval_o      <= 1'b0;
      inval_addr_o <= '0;
    end else begin
      urc_inc_o <= 1'b0;
      exc_o     <= 1'b0;
      inval_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start && assoc) begin
            state_q  <= ST_SCAN;
            idx_q    <= '0;
            found_q  <= 1'b0;
            flush_q  <= 1'b0;
            s_vpn_q  <= w_vpn;
            s_asid_q <= w_asid;
            s_v_q    <= w_v;
            s_d_q    <= w_d;
            s_use_q  <= use_asid_i;
            s_addr_q <= waddr_i;
          end else if (start) begin
            urc_inc_o <= 1'b1;
            if (uent_i[d_idx].v) begin
              inval_o      <= 1'b1;
              inval_addr_o <= {uent_i[d_idx].vpn, {PG_SH{1'b0}}};
            end
          end
        end
        ST_SCAN: begin
          if (u_hit && found_q) begin
            exc_o   <= 1'b1;
            tea_o   <= s_addr_q;
            state_q <= ST_ITLB;
          end else begin
            urc_inc_o <= 1'b1;
            if (u_hit) begin
              found_q <= 1'b1;
              midx_q  <= idx_q;
              if (!s_v_q) flush_q <= 1'b1;
            end
            if (idx_q == UIW'(UTLB_N - 1)) state_q <= ST_ITLB;
            else                           idx_q   <= idx_q + 1'b1;
          end
        end
        ST_ITLB: begin
          state_q      <= ST_IDLE;
          inval_o      <= flush_q || (i_hit && ient_i[i_hidx].v && !s_v_q);
          inval_addr_o <= {s_vpn_q, {PG_SH{1'b0}}};
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_direct_urc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o && !waddr_i[MODE_BIT]) |=> (urc_inc_o && !busy_o));
  p_assoc_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o && waddr_i[MODE_BIT]) |=> busy_o);
  p_mhit_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> !busy_o);
  p_urc_not_exc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(urc_inc_o && exc_o));
  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && !u_hit) |-> (!u_we_o && !i_we_o));
  p_inval_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inval_o && !urc_inc_o) |-> !busy_o);
endmodule

// File: rtl/tlb_addr_wr.sv
module tlb_addr_wr
  import tlbw_pkg::*;
#(
  parameter int UTLB_N = 64,
  parameter int ITLB_N = 4,
  localparam int UIW = $clog2(UTLB_N),
  localparam int IIW = (ITLB_N > 1) ? $clog2(ITLB_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [31:0]       waddr_i,
  input  logic [31:0]       wdata_i,
  input  logic              use_asid_i,
  input  logic              fill_i,
  input  logic              fill_itlb_i,
  input  logic [UIW-1:0]    fill_idx_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_sh_i,
  input  logic              fill_v_i,
  input  logic              fill_d_i,
  input  logic              rd_itlb_i,
  input  logic [UIW-1:0]    rd_idx_i,
  output logic [VPN_W-1:0]  rd_vpn_o,
  output logic [ASID_W-1:0] rd_asid_o,
  output logic              rd_sh_o,
  output logic              rd_v_o,
  output logic              rd_d_o,
  output logic              busy_o,
  output logic              urc_inc_o,
  output logic              exc_o,
  output logic [11:0]       exc_code_o,
  output logic [31:0]       tea_o,
  output logic              inval_o,
  output logic [31:0]       inval_addr_o
);
  tlb_ent_t       uent [UTLB_N];
  tlb_ent_t       ient [ITLB_N];
  tlb_ent_t       fill_ent, u_wdata, i_wdata, rd_ent;
  logic           u_we, i_we;
  logic [UIW-1:0] u_widx;
  logic [IIW-1:0] i_widx;

  assign fill_ent = '{vpn: fill_vpn_i, asid: fill_asid_i, sh: fill_sh_i,
                      v: fill_v_i, d: fill_d_i};

  tlbw_ctrl #(.UTLB_N(UTLB_N), .ITLB_N(ITLB_N)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .waddr_i, .wdata_i, .use_asid_i,
    .fill_i, .fill_itlb_i, .fill_idx_i, .fill_ent_i(fill_ent),
    .uent_i(uent), .ient_i(ient),
    .u_we_o(u_we), .u_widx_o(u_widx), .u_wdata_o(u_wdata),
    .i_we_o(i_we), .i_widx_o(i_widx), .i_wdata_o(i_wdata),
    .busy_o, .urc_inc_o, .exc_o, .tea_o, .inval_o, .inval_addr_o
  );

  tlbw_store #(.DEPTH(UTLB_N)) u_utlb (
    .clk_i, .rst_ni, .we_i(u_we), .widx_i(u_widx), .wdata_i(u_wdata), .ent_o(uent)
  );

  tlbw_store #(.DEPTH(ITLB_N)) u_itlb (
    .clk_i, .rst_ni, .we_i(i_we), .widx_i(i_widx), .wdata_i(i_wdata), .ent_o(ient)
  );

  assign rd_ent     = rd_itlb_i ? ient[rd_idx_i[IIW-1:0]] : uent[rd_idx_i];
  assign rd_vpn_o   = rd_ent.vpn;
  assign rd_asid_o  = rd_ent.asid;
  assign rd_sh_o    = rd_ent.sh;
  assign rd_v_o     = rd_ent.v;
  assign rd_d_o     = rd_ent.d;
  assign exc_code_o = exc_o ? MHIT_CODE : 12'h000;
endmodule

// File: tb/tb_tlb_addr_wr.sv
module tb_tlb_addr_wr;
  import tlbw_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic wr = 0, use_asid = 0, fill = 0, fill_itlb = 0, fill_sh = 0, fill_v = 0, fill_d = 0, rd_itlb = 0;
  logic [31:0] waddr = '0, wdata = '0;
  logic [5:0]  fill_idx = '0, rd_idx = '0;
  logic [21:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [21:0] rd_vpn;
  logic [7:0]  rd_asid;
  logic rd_sh, rd_v, rd_d, busy, urc_inc, exc, inval;
  logic [11:0] exc_code;
  logic [31:0] tea, inval_addr;

  tlb_addr_wr dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .waddr_i(waddr), .wdata_i(wdata),
    .use_asid_i(use_asid), .fill_i(fill), .fill_itlb_i(fill_itlb), .fill_idx_i(fill_idx),
    .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid), .fill_sh_i(fill_sh), .fill_v_i(fill_v),
    .fill_d_i(fill_d), .rd_itlb_i(rd_itlb), .rd_idx_i(rd_idx), .rd_vpn_o(rd_vpn),
    .rd_asid_o(rd_asid), .rd_sh_o(rd_sh), .rd_v_o(rd_v), .rd_d_o(rd_d), .busy_o(busy),
    .urc_inc_o(urc_inc), .exc_o(exc), .exc_code_o(exc_code), .tea_o(tea),
    .inval_o(inval), .inval_addr_o(inval_addr)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // scoreboard: kind 0 = counter strobe, 1 = invalidate, 2 = exception
  int          kq[$];
  logic [31:0] dq[$];
  string       rq[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_ev(input int k, input logic [31:0] d, input string req);
    kq.push_back(k); dq.push_back(d); rq.push_back(req);
  endtask

  task automatic pop_ev(input int k, input logic [31:0] d);
    int ek; logic [31:0] ed; string er;
    if (kq.size() == 0) begin
      chk(0, "R11 unexpected event", 64'(k), 64'hFF);
      return;
    end
    ek = kq.pop_front(); ed = dq.pop_front(); er = rq.pop_front();
    chk(ek == k && ed == d, er, {32'(k), d}, {32'(ek), ed});
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (exc) begin
        pop_ev(2, tea);
        chk(exc_code == 12'h140, "R6 code", 64'(exc_code), 64'h140);
      end
      if (inval)   pop_ev(1, inval_addr);
      if (urc_inc) pop_ev(0, 32'h0);
    end
  end

  function automatic logic [31:0] mkd(input logic [21:0] v, input logic d, input logic vb, input logic [7:0] a);
    return {v, d, vb, a};
  endfunction

  task automatic do_fill(input bit it, input int idx, input logic [21:0] v, input logic [7:0] a,
                         input logic sh, input logic vb, input logic d);
    @(negedge clk);
    fill = 1; fill_itlb = it; fill_idx = 6'(idx); fill_vpn = v; fill_asid = a;
    fill_sh = sh; fill_v = vb; fill_d = d;
    @(negedge clk);
    fill = 0;
  endtask

  task automatic rd_chk(input bit it, input int idx, input tlb_ent_t exp, input string req);
    tlb_ent_t act;
    rd_itlb = it; rd_idx = 6'(idx);
    #1;
    act = '{vpn: rd_vpn, asid: rd_asid, sh: rd_sh, v: rd_v, d: rd_d};
    chk(act == exp, req, 64'(act), 64'(exp));
  endtask

  task automatic direct_wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    wr = 1; waddr = 32'hF600_0000 | (32'(idx) << 8); wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  // search write; returns after busy drops, checks busy length
  task automatic assoc_wr(input logic [31:0] d, input logic ua, input int exp_busy, input string req);
    int n;
    @(negedge clk);
    wr = 1; waddr = 32'hF600_0080; wdata = d; use_asid = ua;
    @(negedge clk);
    wr = 0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == exp_busy, req, 64'(n), 64'(exp_busy));
  endtask

  task automatic push_urc(input int n, input string req);
    for (int i = 0; i < n; i++) push_ev(0, 32'h0, req);
  endtask

  localparam logic [21:0] VA = 22'h0AAAA, VB = 22'h0BBBB, VC = 22'h0CCCC,
                          VD = 22'h0DDDD, VE = 22'h0EEEE, VF = 22'h0F0F0;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !urc_inc && !exc && !inval, "R1 outputs", {busy, urc_inc, exc, inval}, 0);
    rd_chk(0, 0, '0, "R1 utlb entry");
    rd_chk(1, 3, '0, "R1 itlb entry");
    rst_n = 1;

    // R11 fill + readback, no counter strobe
    do_fill(0, 60, 22'h01234, 8'h55, 1, 1, 0);
    rd_chk(0, 60, '{vpn: 22'h01234, asid: 8'h55, sh: 1, v: 1, d: 0}, "R11 fill readback");

    // R2 direct store keeps shared flag
    do_fill(0, 5, 22'h11111, 8'h22, 1, 0, 0);
    push_ev(0, 0, "R2 direct urc");
    direct_wr(5, mkd(22'h12345, 1, 1, 8'h3c));
    chk(!busy, "R2 busy", 64'(busy), 0);
    rd_chk(0, 5, '{vpn: 22'h12345, asid: 8'h3c, sh: 1, v: 1, d: 1}, "R2 direct store");

    // R3 overwrite of valid entry
    push_ev(1, {22'h12345, 10'b0}, "R3 inval old page");
    push_ev(0, 0, "R3 urc");
    direct_wr(5, mkd(22'h2ABCD, 0, 1, 8'h01));
    rd_chk(0, 5, '{vpn: 22'h2ABCD, asid: 8'h01, sh: 1, v: 1, d: 0}, "R3 new entry");

    // R4/R7/R8 search with one unified match
    do_fill(0, 10, VA, 8'h01, 0, 1, 0);
    do_fill(0, 30, VA, 8'h03, 0, 1, 0);
    do_fill(0, 40, VB, 8'h01, 0, 1, 0);
    do_fill(1, 2, VA, 8'h01, 0, 0, 0);
    push_urc(64, "R8 urc per entry");
    assoc_wr(mkd(VA, 1, 1, 8'h01), 1, 65, "R4 busy length");
    rd_chk(0, 10, '{vpn: VA, asid: 8'h01, sh: 0, v: 1, d: 1}, "R4 match updated");
    rd_chk(0, 30, '{vpn: VA, asid: 8'h03, sh: 0, v: 1, d: 0}, "R5 asid mismatch kept");
    rd_chk(0, 40, '{vpn: VB, asid: 8'h01, sh: 0, v: 1, d: 0}, "R4 other page kept");
    rd_chk(1, 2, '{vpn: VA, asid: 8'h01, sh: 0, v: 1, d: 1}, "R7 itlb copy");

    // R5/R9 identifier check off, invalidation
    do_fill(0, 30, VA, 8'h03, 0, 0, 0);
    push_urc(64, "R8 urc");
    push_ev(1, {VA, 10'b0}, "R9 search inval");
    assoc_wr(mkd(VA, 0, 0, 8'h09), 0, 65, "R4 busy length 2");
    rd_chk(0, 10, '{vpn: VA, asid: 8'h01, sh: 0, v: 0, d: 0}, "R5 check-off match");
    rd_chk(1, 2, '{vpn: VA, asid: 8'h01, sh: 0, v: 0, d: 0}, "R7 itlb copy invalid");

    // R5 shared-flag match
    do_fill(0, 20, VC, 8'h05, 1, 1, 0);
    do_fill(1, 0, VC, 8'h07, 0, 1, 0);
    push_urc(64, "R8 urc");
    assoc_wr(mkd(VC, 1, 1, 8'h06), 1, 65, "R4 busy length 3");
    rd_chk(0, 20, '{vpn: VC, asid: 8'h05, sh: 1, v: 1, d: 1}, "R5 shared match");
    rd_chk(1, 0, '{vpn: VC, asid: 8'h07, sh: 0, v: 1, d: 0}, "R7 itlb no match");

    // R7/R9 itlb valid-only update
    do_fill(1, 1, VD, 8'h04, 0, 1, 0);
    push_urc(64, "R8 urc");
    push_ev(1, {VD, 10'b0}, "R9 itlb inval");
    assoc_wr(mkd(VD, 1, 0, 8'h04), 1, 65, "R4 busy length 4");
    rd_chk(1, 1, '{vpn: VD, asid: 8'h04, sh: 0, v: 0, d: 0}, "R7 valid only");

    // R6/R8 duplicate hit at index 7
    do_fill(0, 3, VE, 8'h01, 0, 1, 0);
    do_fill(0, 7, VE, 8'h01, 0, 1, 0);
    do_fill(1, 3, VE, 8'h01, 0, 0, 0);
    push_urc(7, "R8 urc before dup");
    push_ev(2, 32'hF600_0080, "R6 exception tea");
    assoc_wr(mkd(VE, 1, 1, 8'h01), 1, 9, "R6 early stop");
    rd_chk(0, 3, '{vpn: VE, asid: 8'h01, sh: 0, v: 1, d: 1}, "R6 first hit updated");
    rd_chk(0, 7, '{vpn: VE, asid: 8'h01, sh: 0, v: 1, d: 0}, "R6 second hit untouched");
    rd_chk(1, 3, '{vpn: VE, asid: 8'h01, sh: 0, v: 1, d: 1}, "R7 itlb copy after dup");

    // R10 writes and loads during busy ignored
    push_urc(64, "R10 urc");
    @(negedge clk);
    wr = 1; waddr = 32'hF600_0080; wdata = mkd(VF, 1, 1, 8'h01); use_asid = 1;
    @(negedge clk);
    waddr = 32'hF600_0000 | (32'd50 << 8); wdata = mkd(VF, 1, 1, 8'h01);
    @(negedge clk);
    wr = 0; fill = 1; fill_itlb = 0; fill_idx = 6'd51; fill_vpn = VF; fill_v = 1;
    @(negedge clk);
    fill = 0;
    while (busy) @(negedge clk);
    rd_chk(0, 50, '0, "R10 direct ignored");
    rd_chk(0, 51, '0, "R10 fill ignored");

    repeat (4) @(negedge clk);
    chk(kq.size() == 0, "R8 missing events", 64'(kq.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule